// File: doc/BRIEF.md
# Masked SIMD Lane Writeback Unit

This block is the lane-control stage that sits around a packed arithmetic unit working on 64-bit elements in vectors up to 512 bits wide. For each instruction it decodes the encoding class and vector length into a set of active lanes. It then builds the two per-lane operands for an external lane arithmetic unit, replicating a 64-bit memory scalar into every lane when broadcast applies. The per-lane results come back in the same cycle. The block merges them into the final destination register using the writemask, merge-or-zero masking, and the rules for bits above the vector length.

The block also picks which 2-bit rounding mode goes with the result. This is either the mode from the control register or a per-instruction override. The destination and the rounding mode are registered together with a valid flag, so the stage has a latency of one cycle. The arithmetic is not part of the block.

Top module: `vlane_wb`

## Requirements
- R1: `vlen` code 0 selects 128 bits with 2 active lanes, code 1 selects 256 bits with 4 lanes, and codes 2 and 3 select 512 bits with 8 lanes. Lane j occupies bits [64j+63:64j]. Under the legacy encoding (`enc` = 0) the length is always 128 bits, whatever `vlen` holds.
- R2: An active lane receives the arithmetic result from `lane_res` in three cases: its `wmask` bit is set under the masked encoding (`enc` = 2 or 3), or the encoding is legacy (`enc` = 0), or the encoding is the unmasked three-operand one (`enc` = 1). With legacy and unmasked encodings, `wmask` and `zero_mode` have no effect.
- R3: Under the masked encoding, an active lane whose `wmask` bit is clear behaves as follows. With `zero_mode` = 0 it keeps the `old_dst` lane. With `zero_mode` = 1 it becomes zero.
- R4: Broadcast applies when the encoding is masked, `src2_mem` = 1 and `bcast` = 1. In that case every lane of `op_b` equals `src2[63:0]`. Otherwise each lane of `op_b` is the matching lane of `src2`.
- R5: Under the unmasked and masked encodings, every destination bit from the vector length up to bit 511 is zero.
- R6: Under the legacy encoding, `op_a` is taken from `old_dst` and not from `src1`, and destination bits 511:128 keep the value of `old_dst`.
- R7: `out_rm` equals `rm_instr` only when all of these hold: the encoding is masked, the length is 512 bits, `bcast` = 1 and `src2_mem` = 0. In every other case `out_rm` equals `rm_ctl`.
- R8: `wmask` bits at and above the active lane count have no effect on the destination.
- R9: `in_valid` sampled high at a rising edge gives `out_valid` high after that edge, with `out_dst` and `out_rm` for that input. `out_valid` is low after an edge with `in_valid` low. A synchronous active-high reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| vlen | input | 2 | Vector length code (0:128, 1:256, 2/3:512) |
| enc | input | 2 | Encoding class (0 legacy, 1 unmasked, 2/3 masked) |
| wmask | input | 8 | Per-lane write mask |
| zero_mode | input | 1 | 1 zeroes masked-off lanes, 0 merges |
| bcast | input | 1 | Broadcast / rounding-override bit |
| src2_mem | input | 1 | Second source comes from memory |
| rm_ctl | input | 2 | Rounding mode from the control register |
| rm_instr | input | 2 | Per-instruction rounding mode |
| old_dst | input | 512 | Previous destination register value |
| src1 | input | 512 | First source vector |
| src2 | input | 512 | Second source vector or memory data |
| op_a | output | 512 | Per-lane first operand to lane unit |
| op_b | output | 512 | Per-lane second operand to lane unit |
| lane_res | input | 512 | Per-lane results from lane unit |
| out_valid | output | 1 | Registered result valid |
| out_dst | output | 512 | Registered final destination |
| out_rm | output | 2 | Registered selected rounding mode |

## Verification
The assertions check, on every cycle, the following properties:
- the valid pipeline and reset
- broadcast replication on the second operand
- zeroed upper bits for non-legacy 128-bit operations
- preserved upper bits under the legacy encoding
- the fallback to the control-register rounding mode
- an all-zero destination when a masked instruction zeroes with an empty mask

Other behaviours depend on how each lane decides its value, and only the bench's sweep can show them. These are the choice between merge and zero per lane under partial masks, the ignoring of mask bits above the active lanes, the legacy length override, and the correct pairing of results with lanes. The sweep covers every length, encoding, masking mode, broadcast and source combination, and compares against a model that subtracts the lanes as integers.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

    parameter int LANE_W    = 64;
    parameter int MAX_W     = 512;
    parameter int MAX_LANES = MAX_W / LANE_W;
    parameter int RM_W      = 2;

    typedef enum logic [1:0] {
        ENC_LEGACY = 2'd0,
        ENC_PLAIN  = 2'd1,
        ENC_MASKED = 2'd2,
        ENC_MASKX  = 2'd3
    } enc_e;

    typedef enum logic [1:0] {
        LEN_128  = 2'd0,
        LEN_256  = 2'd1,
        LEN_512  = 2'd2,
        LEN_512X = 2'd3
    } len_e;

    typedef struct packed {
        logic                 legacy;
        logic                 masked;
        logic                 bcast_eff;
        logic                 zero_eff;
        logic [MAX_LANES-1:0] act;
        logic [MAX_LANES-1:0] wen;
    } lane_ctl_t;

    function automatic int lanes_for(input len_e code);
        case (code)
            LEN_128: return 128 / LANE_W;
            LEN_256: return 256 / LANE_W;
            default: return MAX_W / LANE_W;
        endcase
    endfunction

    function automatic logic [MAX_LANES-1:0] active_set(input len_e code);
        logic [MAX_LANES-1:0] m;
        int n;
        n = lanes_for(code);
        for (int j = 0; j < MAX_LANES; j++) begin
            m[j] = (j < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/vlane_ctrl.sv
module vlane_ctrl
    import vlane_pkg::*;
(
    input  logic [1:0]           vlen,
    input  logic [1:0]           enc,
    input  logic [MAX_LANES-1:0] wmask,
    input  logic                 zero_mode,
    input  logic                 bcast,
    input  logic                 src2_mem,
    input  logic [RM_W-1:0]      rm_ctl,
    input  logic [RM_W-1:0]      rm_instr,
    output lane_ctl_t            ctl,
    output logic [RM_W-1:0]      rm_sel
);

    len_e eff_len;
    logic is_legacy;
    logic is_masked;
    logic rm_override;

    always_comb begin
        is_legacy = (enc_e'(enc) == ENC_LEGACY);
        is_masked = enc[1];
        eff_len   = is_legacy ? LEN_128 : len_e'(vlen);

        ctl.legacy    = is_legacy;
        ctl.masked    = is_masked;
        ctl.bcast_eff = is_masked & bcast & src2_mem;
        ctl.zero_eff  = is_masked & zero_mode;
        ctl.act       = active_set(eff_len);
        ctl.wen       = ctl.act & (is_masked ? wmask : {MAX_LANES{1'b1}});

        rm_override = is_masked & eff_len[1] & bcast & ~src2_mem;
        rm_sel      = rm_override ? rm_instr : rm_ctl;
    end

endmodule

// File: rtl/vlane_opsel.sv
module vlane_opsel
    import vlane_pkg::*;
(
    input  lane_ctl_t        ctl,
    input  logic [MAX_W-1:0] old_dst,
    input  logic [MAX_W-1:0] src1,
    input  logic [MAX_W-1:0] src2,
    output logic [MAX_W-1:0] op_a,
    output logic [MAX_W-1:0] op_b
);

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        localparam int LO = j * LANE_W;
        always_comb begin
            op_a[LO +: LANE_W] = ctl.legacy    ? old_dst[LO +: LANE_W] : src1[LO +: LANE_W];
            op_b[LO +: LANE_W] = ctl.bcast_eff ? src2[LANE_W-1:0]      : src2[LO +: LANE_W];
        end
    end

endmodule

// File: rtl/vlane_merge.sv
module vlane_merge
    import vlane_pkg::*;
(
    input  lane_ctl_t        ctl,
    input  logic [MAX_W-1:0] old_dst,
    input  logic [MAX_W-1:0] lane_res,
    output logic [MAX_W-1:0] merged
);

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        localparam int LO = j * LANE_W;
        always_comb begin
            if (ctl.wen[j]) begin
                merged[LO +: LANE_W] = lane_res[LO +: LANE_W];
            end else if (ctl.act[j]) begin
                merged[LO +: LANE_W] = ctl.zero_eff ? '0 : old_dst[LO +: LANE_W];
            end else begin
                merged[LO +: LANE_W] = ctl.legacy ? old_dst[LO +: LANE_W] : '0;
            end
        end
    end

endmodule

// File: rtl/vlane_wb.sv
module vlane_wb
    import vlane_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           vlen,
    input  logic [1:0]           enc,
    input  logic [MAX_LANES-1:0] wmask,
    input  logic                 zero_mode,
    input  logic                 bcast,
    input  logic                 src2_mem,
    input  logic [RM_W-1:0]      rm_ctl,
    input  logic [RM_W-1:0]      rm_instr,
    input  logic [MAX_W-1:0]     old_dst,
    input  logic [MAX_W-1:0]     src1,
    input  logic [MAX_W-1:0]     src2,
    output logic [MAX_W-1:0]     op_a,
    output logic [MAX_W-1:0]     op_b,
    input  logic [MAX_W-1:0]     lane_res,
    output logic                 out_valid,
    output logic [MAX_W-1:0]     out_dst,
    output logic [RM_W-1:0]      out_rm
);

    lane_ctl_t        ctl;
    logic [RM_W-1:0]  rm_sel;
    logic [MAX_W-1:0] merged;

    vlane_ctrl u_ctrl (
        .vlen      (vlen),
        .enc       (enc),
        .wmask     (wmask),
        .zero_mode (zero_mode),
        .bcast     (bcast),
        .src2_mem  (src2_mem),
        .rm_ctl    (rm_ctl),
        .rm_instr  (rm_instr),
        .ctl       (ctl),
        .rm_sel    (rm_sel)
    );

    vlane_opsel u_opsel (
        .ctl     (ctl),
        .old_dst (old_dst),
        .src1    (src1),
        .src2    (src2),
        .op_a    (op_a),
        .op_b    (op_b)
    );

    vlane_merge u_merge (
        .ctl      (ctl),
        .old_dst  (old_dst),
        .lane_res (lane_res),
        .merged   (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_dst   <= '0;
            out_rm    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_dst <= merged;
                out_rm  <= rm_sel;
            end
        end
    end

endmodule

// File: rtl/vlane_wb_chk.sv
module vlane_wb_chk
    import vlane_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [1:0]           vlen,
    input logic [1:0]           enc,
    input logic [MAX_LANES-1:0] wmask,
    input logic                 zero_mode,
    input logic                 bcast,
    input logic                 src2_mem,
    input logic [RM_W-1:0]      rm_ctl,
    input logic [MAX_W-1:0]     old_dst,
    input logic [MAX_W-1:0]     src2,
    input logic [MAX_W-1:0]     op_b,
    input logic                 out_valid,
    input logic [MAX_W-1:0]     out_dst,
    input logic [RM_W-1:0]      out_rm
);

    logic bc_on;
    logic rm_forced;
    assign bc_on     = enc[1] & bcast & src2_mem;
    assign rm_forced = enc[1] & vlen[1] & bcast & ~src2_mem;

    // R9
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R4
    a_r4_bcast_lane1: assert property (@(posedge clk) disable iff (rst)
        bc_on |-> (op_b[2*LANE_W-1:LANE_W] == src2[LANE_W-1:0]));
    a_r4_bcast_top: assert property (@(posedge clk) disable iff (rst)
        bc_on |-> (op_b[MAX_W-1:MAX_W-LANE_W] == src2[LANE_W-1:0]));

    // R5
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && enc != 2'd0 && vlen == 2'd0) |=> (out_dst[MAX_W-1:128] == '0));

    // R6
    a_r6_legacy_keep: assert property (@(posedge clk) disable iff (rst)
        (in_valid && enc == 2'd0) |=> (out_dst[MAX_W-1:128] == $past(old_dst[MAX_W-1:128])));

    // R7
    a_r7_ctl_mode: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rm_forced) |=> (out_rm == $past(rm_ctl)));

    // R3
    a_r3_zero_all: assert property (@(posedge clk) disable iff (rst)
        (in_valid && enc[1] && zero_mode && wmask == '0) |=> (out_dst == '0));

endmodule

bind vlane_wb vlane_wb_chk u_vlane_wb_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .vlen      (vlen),
    .enc       (enc),
    .wmask     (wmask),
    .zero_mode (zero_mode),
    .bcast     (bcast),
    .src2_mem  (src2_mem),
    .rm_ctl    (rm_ctl),
    .old_dst   (old_dst),
    .src2      (src2),
    .op_b      (op_b),
    .out_valid (out_valid),
    .out_dst   (out_dst),
    .out_rm    (out_rm)
);

// File: tb/test_vlane_wb.sv
`timescale 1ns/1ps
module test_vlane_wb;

    localparam int LW = 64;
    localparam int NL = 8;
    localparam int W  = 512;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    vlen = '0, enc = '0;
    logic [NL-1:0] wmask = '0;
    logic          zero_mode = 1'b0, bcast = 1'b0, src2_mem = 1'b0;
    logic [1:0]    rm_ctl = '0, rm_instr = '0;
    logic [W-1:0]  old_dst = '0, src1 = '0, src2 = '0;
    logic [W-1:0]  op_a, op_b, lane_res;
    logic          out_valid;
    logic [W-1:0]  out_dst;
    logic [1:0]    out_rm;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    typedef struct {
        logic [W-1:0] dst;
        logic [1:0]   rm;
        string        tag [NL];
        string        rm_tag;
    } exp_t;

    exp_t sb [$];

    always #4 clk = ~clk;

    // external lane unit model: integer subtraction per lane
    always_comb begin
        for (int j = 0; j < NL; j++) begin
            lane_res[j*LW +: LW] = op_a[j*LW +: LW] - op_b[j*LW +: LW];
        end
    end

    vlane_wb i_vlane_wb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .vlen(vlen), .enc(enc),
        .wmask(wmask), .zero_mode(zero_mode), .bcast(bcast), .src2_mem(src2_mem),
        .rm_ctl(rm_ctl), .rm_instr(rm_instr), .old_dst(old_dst), .src1(src1),
        .src2(src2), .op_a(op_a), .op_b(op_b), .lane_res(lane_res),
        .out_valid(out_valid), .out_dst(out_dst), .out_rm(out_rm)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic logic [W-1:0] rnd512();
        logic [W-1:0] v;
        for (int k = 0; k < W/32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // driver: applies one item at a negedge and pushes its expectation
    task automatic drive(input logic [1:0] l, input logic [1:0] e, input logic [NL-1:0] m,
                         input logic z, input logic b, input logic mem);
        exp_t x;
        bit legacy, masked, bc, ovr;
        int n;
        logic [LW-1:0] a, bb;
        @(negedge clk);
        vlen = l; enc = e; wmask = m; zero_mode = z; bcast = b; src2_mem = mem;
        rm_ctl = 2'($urandom); rm_instr = 2'($urandom);
        old_dst = rnd512(); src1 = rnd512(); src2 = rnd512();
        in_valid = 1'b1;
        legacy = (e == 2'd0);
        masked = e[1];
        bc     = masked && b && mem;
        n      = legacy ? 2 : (l == 2'd0 ? 2 : (l == 2'd1 ? 4 : 8));
        for (int j = 0; j < NL; j++) begin
            a  = legacy ? old_dst[j*LW +: LW] : src1[j*LW +: LW];
            bb = bc ? src2[LW-1:0] : src2[j*LW +: LW];
            if (j < n) begin
                if (!masked || m[j]) begin
                    x.dst[j*LW +: LW] = a - bb;
                    x.tag[j] = bc ? "R4" : (legacy ? "R6" : "R2");
                end else begin
                    x.dst[j*LW +: LW] = z ? '0 : old_dst[j*LW +: LW];
                    x.tag[j] = "R3";
                end
            end else begin
                x.dst[j*LW +: LW] = legacy ? old_dst[j*LW +: LW] : '0;
                if (masked && m[j])        x.tag[j] = "R8";
                else if (legacy && l != 0) x.tag[j] = "R1";
                else                       x.tag[j] = legacy ? "R6" : "R5";
            end
        end
        ovr      = masked && !legacy && l[1] && b && !mem;
        x.rm     = ovr ? rm_instr : rm_ctl;
        x.rm_tag = "R7";
        sb.push_back(x);
    endtask

    task automatic idle(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: pops and compares every valid output
    initial begin
        exp_t x;
        forever begin
            @(negedge clk);
            if (!rst && !done) begin
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R9", W'(out_valid), W'(0));
                    end else begin
                        x = sb.pop_front();
                        for (int j = 0; j < NL; j++) begin
                            check(out_dst[j*LW +: LW] == x.dst[j*LW +: LW], x.tag[j],
                                  W'(out_dst[j*LW +: LW]), W'(x.dst[j*LW +: LW]));
                        end
                        check(out_rm == x.rm, x.rm_tag, W'(out_rm), W'(x.rm));
                    end
                end else begin
                    // R9: nothing pending means no valid expected
                    check(sb.size() == 0, "R9", W'(sb.size()), W'(0));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [NL-1:0] masks [4];
        masks[0] = 8'h00; masks[1] = 8'hFF; masks[2] = 8'hA5; masks[3] = 8'h3C;
        repeat (3) @(negedge clk);
        // R9: reset clears valid
        check(out_valid == 1'b0, "R9", W'(out_valid), W'(0));
        rst = 1'b0;
        for (int e = 0; e < 4; e++)
            for (int l = 0; l < 4; l++)
                for (int z = 0; z < 2; z++)
                    for (int b = 0; b < 2; b++)
                        for (int mem = 0; mem < 2; mem++)
                            for (int mi = 0; mi < 4; mi++) begin
                                drive(2'(l), 2'(e), masks[mi], 1'(z), 1'(b), 1'(mem));
                                if (mi == 2) idle(1);
                            end
        idle(4);
        // R9: idle stage shows no valid
        check(out_valid == 1'b0, "R9", W'(out_valid), W'(0));
        check(sb.size() == 0, "R9", W'(sb.size()), W'(0));
        done = 1;
        finish_run();
    end

endmodule